// File: doc/BRIEF.md
# Receive Byte Queue with Per-Byte Error Status

This block sits between a serial receiver and an 8-bit host bus. The receiver pushes one 10-bit word per received character: eight data bits plus a framing-error flag and a parity-error flag. The words wait in a 16-entry first-in first-out store. The host sees a data register and a two-bit status register. Both always describe the same received character.

A read strobe on the data register takes the oldest stored word. It loads that word's data byte and its two error flags into the two registers at the same clock edge. The status of a character is therefore valid from the pop that presented it until the next pop. Host software reads status first and then pulses the data read. A strobe while the store is empty leaves both registers as they were.

Occupancy is exported as a count, an empty flag, a full flag and a half-full flag, so that a separate interrupt block can derive threshold and timeout events. When a word arrives while the store is full, it is discarded and a one-cycle overrun pulse is raised for a sticky flag elsewhere. A synchronous clear discards all stored words and zeroes both host registers.

Top module: `rxq_status_fifo`

## Requirements
- R1: After reset, count_o is 0, empty_o is 1, full_o, half_o and drop_o are 0, and data_o and stat_o are 0.
- R2: A written word carries the data byte in bits 7:0, the framing-error flag in bit 8 and the parity-error flag in bit 9. Accepted words leave in the order they were written.
- R3: When rd_strb_i is high at a clock edge and the store is not empty, data_o and stat_o take the oldest word's byte and flags from that edge on. count_o then drops by one unless a write is accepted at the same edge.
- R4: stat_o shows {parity-error, framing-error} (bit 1 parity, bit 0 framing) of the byte in data_o. It holds until the next pop, which overwrites it whether or not it was read.
- R5: A read strobe while count_o is 0 leaves data_o, stat_o and count_o unchanged.
- R6: The store holds 16 words, and full_o is 1 exactly when count_o is 16.
- R7: A write while full_o is 1 is discarded, even if a pop happens at the same edge, and the stored words are unchanged. drop_o is 1 for the single cycle after that edge.
- R8: count_o gives the number of stored words (0 to 16), not counting the byte in data_o. empty_o is 1 when it is 0, and half_o is 1 when it is 8 or more.
- R9: clr_i high at an edge empties the store, zeroes data_o, stat_o and drop_o, and overrides any write or read at that edge.
- R10: A write and a pop at the same edge, with the store neither empty nor full, leave count_o unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of store and host registers |
| wr_vld_i | input | 1 | Receiver word valid |
| wr_word_i | input | 10 | {parity err, framing err, data[7:0]} |
| full_o | output | 1 | Store holds 16 words |
| drop_o | output | 1 | One-cycle overrun pulse after a discarded write |
| rd_strb_i | input | 1 | Host data-register read strobe (pop) |
| data_o | output | 8 | Data register |
| stat_o | output | 2 | Status register {parity err, framing err} |
| empty_o | output | 1 | Store holds no word |
| half_o | output | 1 | Count is 8 or more |
| count_o | output | 5 | Number of stored words |

## Verification
Every result is registered, so a write, strobe or clear applied before a rising edge shows up on count_o, the flags, data_o, stat_o and drop_o right after that edge, with nothing due later. The bench drives inputs at the falling edge. It updates its reference queue at the rising edge and compares every output at the next falling edge, so each comparison looks at the cycle in which the result is due. The strobe-on-empty, overrun and clear cases are compared at that same falling edge, before the next stimulus can change anything.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DW = 8;
  localparam int RXQ_SW = 2;
  localparam int RXQ_EW = RXQ_DW + RXQ_SW;

  // packed MSB first: parity error is bit 9, framing error bit 8
  typedef struct packed {
    logic              par_err;
    logic              frm_err;
    logic [RXQ_DW-1:0] data;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       wr_vld_i,
  input  rxq_entry_t                 wr_ent_i,
  input  logic                       rd_req_i,
  output rxq_entry_t                 head_o,
  output logic                       pop_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       full_o,
  output logic                       empty_o,
  output logic                       drop_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH-1);

  rxq_entry_t    mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW-1:0] rptr_q, rptr_d;
  logic [CW-1:0] cnt_q,  cnt_d;
  logic          drop_q, drop_d;
  logic          wr_ok, rd_ok;
  logic [DEPTH-1:0] slot_we;

  assign full_o  = (cnt_q == CNT_FULL);
  assign empty_o = (cnt_q == '0);
  assign wr_ok   = wr_vld_i & ~full_o & ~clr_i;
  assign rd_ok   = rd_req_i & ~empty_o & ~clr_i;

  // one write enable per slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot_we
    assign slot_we[g] = wr_ok & (wptr_q == AW'(g));
  end

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    drop_d = 1'b0;
    if (clr_i) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      drop_d = wr_vld_i & full_o;
      if (wr_ok) wptr_d = (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
      if (rd_ok) rptr_d = (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      drop_q <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      drop_q <= drop_d;
    end
  end

  // storage array: no reset, written only through slot enables
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) mem_q[i] <= wr_ent_i;
    end
  end

  assign head_o  = mem_q[rptr_q];
  assign pop_o   = rd_ok;
  assign count_o = cnt_q;
  assign drop_o  = drop_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL); // R6
  AST_DROP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld_i && full_o && !clr_i) |=> (drop_o && cnt_q != '0)); // R7
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (empty_o && !drop_o)); // R9
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && !empty_o && !wr_vld_i && !clr_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
endmodule

// File: rtl/rxq_head_reg.sv
module rxq_head_reg
  import rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              load_i,
  input  rxq_entry_t        ent_i,
  output logic [RXQ_DW-1:0] data_o,
  output logic [RXQ_SW-1:0] stat_o
);
  logic [RXQ_DW-1:0] data_q, data_d;
  logic [RXQ_SW-1:0] stat_q, stat_d;
  logic              en;

  assign en = clr_i | load_i;

  always_comb begin
    data_d = data_q;
    stat_d = stat_q;
    if (clr_i) begin
      data_d = '0;
      stat_d = '0;
    end else if (load_i) begin
      data_d = ent_i.data;
      stat_d = {ent_i.par_err, ent_i.frm_err};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      stat_q <= '0;
    end else if (en) begin
      data_q <= data_d;
      stat_q <= stat_d;
    end
  end

  assign data_o = data_q;
  assign stat_o = stat_q;

  AST_LOAD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_i) |=> (data_o == $past(ent_i.data) &&
                            stat_o == {$past(ent_i.par_err), $past(ent_i.frm_err)})); // R4
endmodule

// File: rtl/rxq_status_fifo.sv
module rxq_status_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       wr_vld_i,
  input  logic [RXQ_EW-1:0]          wr_word_i,
  output logic                       full_o,
  output logic                       drop_o,
  input  logic                       rd_strb_i,
  output logic [RXQ_DW-1:0]          data_o,
  output logic [RXQ_SW-1:0]          stat_o,
  output logic                       empty_o,
  output logic                       half_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);

  rxq_entry_t head;
  rxq_entry_t wr_ent;
  logic       pop;

  assign wr_ent = rxq_entry_t'(wr_word_i);

  rxq_store #(.DEPTH(DEPTH)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_i),
    .wr_vld_i (wr_vld_i),
    .wr_ent_i (wr_ent),
    .rd_req_i (rd_strb_i),
    .head_o   (head),
    .pop_o    (pop),
    .count_o  (count_o),
    .full_o   (full_o),
    .empty_o  (empty_o),
    .drop_o   (drop_o)
  );

  rxq_head_reg head_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .load_i (pop),
    .ent_i  (head),
    .data_o (data_o),
    .stat_o (stat_o)
  );

  assign half_o = (count_o >= CNT_HALF);

  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strb_i && empty_o && !clr_i) |=> ($stable(data_o) && $stable(stat_o))); // R5
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (data_o == '0 && stat_o == '0 && count_o == '0)); // R9
  AST_SIMUL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld_i && rd_strb_i && !empty_o && !full_o && !clr_i) |=> $stable(count_o)); // R10
endmodule

// File: tb/rxq_status_fifo_tb.sv
module rxq_status_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr_i;
  logic       wr_vld_i;
  logic [9:0] wr_word_i;
  logic       rd_strb_i;
  logic       full_o, drop_o, empty_o, half_o;
  logic [7:0] data_o;
  logic [1:0] stat_o;
  logic [4:0] count_o;

  int errors = 0;
  int checks = 0;
  logic [9:0] q[$];
  logic [7:0] m_data;
  logic [1:0] m_stat;
  logic       m_drop;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_status_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .wr_vld_i(wr_vld_i), .wr_word_i(wr_word_i), .full_o(full_o), .drop_o(drop_o),
    .rd_strb_i(rd_strb_i), .data_o(data_o), .stat_o(stat_o),
    .empty_o(empty_o), .half_o(half_o), .count_o(count_o)
  );

  function automatic logic exp_half(int n);
    return n >= DEPTH/2;
  endfunction

  function automatic logic [1:0] exp_stat(logic [9:0] w);
    return {w[9], w[8]};
  endfunction

  task automatic chk(string fld, string req, int act, int exp, string scen);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s (%s): actual=%0d expected=%0d", req, fld, scen, act, exp);
    end
  endtask

  task automatic check_all(string scen);
    chk("count",  "R8", int'(count_o), q.size(), scen);
    chk("empty",  "R8", int'(empty_o), int'(q.size() == 0), scen);
    chk("half",   "R8", int'(half_o),  int'(exp_half(q.size())), scen);
    chk("full",   "R6", int'(full_o),  int'(q.size() == DEPTH), scen);
    chk("data",   "R3", int'(data_o),  int'(m_data), scen);
    chk("status", "R4", int'(stat_o),  int'(m_stat), scen);
    chk("drop",   "R7", int'(drop_o),  int'(m_drop), scen);
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(logic wr, logic [9:0] w, logic rd, logic clr, string scen);
    int n;
    logic [9:0] hd;
    wr_vld_i = wr; wr_word_i = w; rd_strb_i = rd; clr_i = clr;
    @(posedge clk);
    n = q.size();
    if (clr) begin
      q.delete(); m_data = '0; m_stat = '0; m_drop = 1'b0;
    end else begin
      m_drop = wr && (n == DEPTH);
      if (rd && n > 0) begin
        hd = q.pop_front();
        m_data = hd[7:0];
        m_stat = exp_stat(hd);
      end
      if (wr && n < DEPTH) q.push_back(w);
    end
    @(negedge clk);
    wr_vld_i = 1'b0; rd_strb_i = 1'b0; clr_i = 1'b0;
    check_all(scen);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C5A_7E01));
    rst_n = 1'b0; clr_i = 1'b0; wr_vld_i = 1'b0; wr_word_i = '0; rd_strb_i = 1'b0;
    m_data = '0; m_stat = '0; m_drop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset state");

    // R5: strobe on empty after reset
    step(0, '0, 1, 0, "R5 pop on empty");

    // R2/R6: fill to 16 with distinct bytes and all status combinations
    for (int i = 0; i < DEPTH; i++) step(1, {i[1:0], 8'(8'hA0 + i)}, 0, 0, "R2 fill");
    // R7: 17th write rejected, then pulse ends
    step(1, 10'h3FF, 0, 0, "R7 write when full");
    step(0, '0, 0, 0, "R7 pulse ends");
    // R7: write while full with same-edge pop is still dropped
    step(1, 10'h155, 1, 0, "R7 full write with pop");

    // R4: interleaved status/data reads, status held between pops
    for (int i = 0; i < DEPTH - 1; i++) begin
      step(0, '0, 1, 0, "R3 pop in order");
      step(0, '0, 0, 0, "R4 status held");
    end
    step(0, '0, 1, 0, "R5 pop on empty keeps last byte");
    step(0, '0, 1, 0, "R5 second pop on empty");

    // R10: simultaneous write and pop
    for (int i = 0; i < 3; i++) step(1, 10'(10'h240 + i), 0, 0, "R10 prefill");
    step(1, 10'h1C7, 1, 0, "R10 write and pop");
    step(1, 10'h0E1, 1, 0, "R10 write and pop again");

    // R9: clear overrides write and read
    step(1, 10'h2AA, 1, 1, "R9 clear with traffic");
    step(0, '0, 1, 0, "R9 pop after clear");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic wr, rd, cl;
      wr = ($urandom % 100) < 55;
      rd = ($urandom % 100) < 45;
      cl = ($urandom % 300) == 0;
      step(wr, 10'($urandom), rd, cl, "random R2 R10");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule